// File: doc/BRIEF.md
# Receive FIFO with Watermark Transfer Request

This block is the receive-side buffer of a serial port. Words from the deserializer go into a first-in first-out store. A processor or a DMA engine drains that store through a read port. A status block reports a full flag and a transfer-request flag. The request rises when the number of buffered words goes above a programmable watermark. It drops for one cycle after every DMA access, so the DMA engine sees a fresh edge for each burst beat. It rises again only if the threshold is still crossed.

A single level interrupt combines the two flags through separate enables. While reception is turned off, every status output reads zero and the store is emptied. Software uses the watermark to trade interrupt or DMA rate against latency.

Top module: `rx_wm_fifo`

## Requirements
- R1: While `rx_en` is 0, `status`, `overflow` and `rd_data` read 0, and pushes and reads have no effect. On the first clock with `rx_en` at 0, `level` becomes 0 and the stored words are discarded. `irq` reads 0 from the following cycle.
- R2: Words are returned in push order. `rd_data` shows the oldest stored word during the cycle in which `rd_cpu` or `rd_dma` is high, and that word is removed at the clock edge.
- R3: `status[3]` (the full flag) is 1 exactly when `level` equals DEPTH. It returns to 0 on the clock edge that removes a word.
- R4: `status[2]` (the transfer request) becomes 1 at the clock edge where the new `level` is strictly greater than `watermark`. A `level` equal to `watermark` does not set it.
- R5: The transfer request becomes 0 at the clock edge where the new `level` is below `watermark`. When the new `level` equals `watermark`, the request keeps its value.
- R6: After every cycle with `rd_dma` high, the transfer request is 0 for the next cycle. On the edge after that, it is raised again if R4 still holds.
- R7: `irq` is a registered level. In each cycle it equals the value, one cycle earlier, of (`ie_full` AND `status[3]`) OR (`ie_req` AND `status[2]`).
- R8: `status[1:0]` are reserved and always read 0, whatever the inputs do.
- R9: A push while `level` equals DEPTH is dropped and sets the sticky `overflow` bit, which stays set until reception is disabled. A read while empty returns 0 and leaves `level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; 0 flushes the store and silences status |
| push_valid | input | 1 | Incoming word strobe from the deserializer |
| push_data | input | WIDTH | Incoming word |
| rd_cpu | input | 1 | Processor read of the data port (removes one word) |
| rd_dma | input | 1 | DMA access of the data port (removes one word, drops request) |
| rd_data | output | WIDTH | Oldest stored word, 0 if empty or disabled |
| watermark | input | AW | Request threshold, 0 to DEPTH-1 |
| ie_full | input | 1 | Interrupt enable for the full flag |
| ie_req | input | 1 | Interrupt enable for the transfer request |
| status | output | 4 | [3] full, [2] transfer request, [1:0] reserved zero |
| overflow | output | 1 | Sticky dropped-push indicator |
| level | output | AW+1 | Number of stored words |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench puts `level` exactly at the watermark. A design that compares with greater-or-equal would raise the request there, and one that clears at equality would drop it early. It issues single DMA accesses while the count stays above the threshold. A design that only clears on the threshold would keep the request high through the access, and one that latches the clear would never raise it again. It fills the store past DEPTH and reads it empty and beyond. These cases expose a wrapped count, a corrupted word order or a nonzero empty read. It also turns reception off while words are held, which would reveal stale data or status that is not silenced.

// File: rtl/rx_wm_fifo.sv
module rx_wm_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             rd_cpu,
  input  logic             rd_dma,
  output logic [WIDTH-1:0] rd_data,
  input  logic [AW-1:0]    watermark,
  input  logic             ie_full,
  input  logic             ie_req,
  output logic [3:0]       status,
  output logic             overflow,
  output logic [CW-1:0]    level,
  output logic             irq
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic req_q, ovf_q, irq_q;
  logic is_full, is_empty, push_ok, pop_ok, req_nxt;

  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign push_ok  = rx_en && push_valid && !is_full;
  assign pop_ok   = rx_en && (rd_cpu || rd_dma) && !is_empty;
  assign cnt_nxt  = cnt + CW'(push_ok) - CW'(pop_ok);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (!rx_en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt_nxt;
    end
  end

  always_comb begin
    if (!rx_en || rd_dma)                 req_nxt = 1'b0;
    else if (cnt_nxt > CW'(watermark))    req_nxt = 1'b1;
    else if (cnt_nxt < CW'(watermark))    req_nxt = 1'b0;
    else                                  req_nxt = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
      if (!rx_en)                        ovf_q <= 1'b0;
      else if (push_valid && is_full)    ovf_q <= 1'b1;
      irq_q <= (ie_full && status[3]) || (ie_req && status[2]);
    end
  end

  assign rd_data  = (rx_en && !is_empty) ? mem[rd_ptr] : '0;
  assign status   = {rx_en && is_full, rx_en && req_q, 2'b00};
  assign overflow = rx_en && ovf_q;
  assign level    = cnt;
  assign irq      = irq_q;

  a_r1_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (level == '0));
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (status == 4'b0 && !overflow && rd_data == '0));
  a_r3_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && status[3] && (rd_cpu || rd_dma) && !push_valid) |=> !status[3]);
  a_r4_req_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rd_dma && cnt_nxt > CW'(watermark)) |=> (!rx_en || status[2]));
  a_r6_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dma |=> !status[2]);
  a_r7_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past((ie_full && status[3]) || (ie_req && status[2]))));
  a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && push_valid && status[3] && !rd_cpu && !rd_dma)
      |=> ((!rx_en || overflow) && level == CW'(DEPTH)));
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

endmodule

// File: tb/test_rx_wm_fifo.sv
module test_rx_wm_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, rx_en = 0, push_valid = 0, rd_cpu = 0, rd_dma = 0;
  logic ie_full = 0, ie_req = 0;
  logic [WIDTH-1:0] push_data = '0;
  logic [AW-1:0] watermark = '0;
  logic [WIDTH-1:0] rd_data;
  logic [3:0] status;
  logic overflow, irq;
  logic [AW:0] level;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [WIDTH-1:0] exp_q[$];

  always #2 clk = ~clk;

  rx_wm_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rx_wm_fifo (
    .clk, .rst_n, .rx_en, .push_valid, .push_data, .rd_cpu, .rd_dma, .rd_data,
    .watermark, .ie_full, .ie_req, .status, .overflow, .level, .irq);

  task automatic chk(string rq, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (rd_cpu || rd_dma)) begin
      if (rx_en && exp_q.size() > 0) chk("R2 read order", rd_data, exp_q.pop_front());
      else chk("R9 empty/disabled read", rd_data, 0);
    end
  end

  // driver: one clock with the given strobes
  task automatic cyc(bit pv, bit rc, bit rd);
    bit acc;
    logic [WIDTH-1:0] d;
    d = $urandom();
    acc = pv && rx_en && (exp_q.size() < DEPTH);
    push_valid = pv; push_data = d; rd_cpu = rc; rd_dma = rd;
    @(posedge clk); #1;
    if (acc) exp_q.push_back(d);
    if (!rx_en) exp_q.delete();
    push_valid = 0; rd_cpu = 0; rd_dma = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", status, 0);
    chk("R1 reset level", level, 0);
    chk("R7 reset irq", irq, 0);
    rst_n = 1;
    cyc(1, 0, 0);
    chk("R1 push ignored when disabled", level, 0);
    rx_en = 1; watermark = 4; ie_req = 1;
    cyc(0, 1, 0);
    chk("R9 empty read keeps level", level, 0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);
    chk("R4 equality no request", status[2], 0);
    cyc(1, 0, 0);
    chk("R4 above watermark request", status[2], 1);
    chk("R7 irq lags request", irq, 0);
    chk("R8 reserved zero", status[1:0], 0);
    cyc(0, 0, 0);
    chk("R7 irq follows request", irq, 1);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0);
    chk("R2 level after pushes", level, 8);
    cyc(0, 0, 1);
    chk("R6 request dropped after DMA", status[2], 0);
    cyc(0, 0, 0);
    chk("R6 request raised again", status[2], 1);
    cyc(0, 1, 0); cyc(0, 1, 0);
    chk("R5 above keeps request", status[2], 1);
    cyc(0, 1, 0);
    chk("R5 equality holds request", status[2], 1);
    cyc(0, 1, 0);
    chk("R5 below clears request", status[2], 0);
    ie_full = 1;
    for (int i = 0; i < 20; i++) cyc(1, 0, 0);
    chk("R3 full flag", status[3], 1);
    chk("R9 overflow sticky", overflow, 1);
    chk("R9 level capped", level, DEPTH);
    chk("R7 irq with full", irq, 1);
    chk("R8 reserved zero when full", status[1:0], 0);
    cyc(0, 1, 0);
    chk("R3 full clears after read", status[3], 0);
    chk("R9 overflow stays", overflow, 1);
    for (int i = 0; i < 6; i++) cyc(i % 2 == 0, i % 3 == 0, i % 3 == 1);
    rx_en = 0;
    #1;
    chk("R1 status silenced", status, 0);
    chk("R1 overflow silenced", overflow, 0);
    chk("R1 rd_data zero", rd_data, 0);
    cyc(0, 1, 0);
    chk("R1 flushed level", level, 0);
    cyc(0, 0, 0);
    chk("R1 irq quiet", irq, 0);
    rx_en = 1;
    cyc(0, 0, 0);
    chk("R1 empty after re-enable", level, 0);
    chk("R9 overflow cleared", overflow, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0);
    chk("R2 drained", level, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule